// File: doc/BRIEF.md
# Serial DAC Word Transmitter

This block feeds an audio DAC that takes its samples over a three-wire serial link: a bit clock, a data line and a latch-enable strobe. Samples are 18-bit two's-complement values. They arrive on a valid/ready handshake. Each accepted sample goes out as a 24-slot frame. The first six slots repeat the sample's sign bit. The remaining eighteen slots carry the sample itself, most significant bit first. The DAC keeps only the last eighteen bits it shifted in before the strobe fell, so the leading copies of the sign bit do no harm.

The bit clock comes from the system clock through a divider whose ratio is a parameter. Each bit slot opens on a falling bit-clock edge. The data line changes only at that edge, so it is steady when the DAC samples it on the rising edge. The strobe goes high at the start of the second slot. It goes low at the falling edge that closes the last slot. If no sample is waiting at that moment, the bit clock stops low and the strobe stays low until the next frame has delivered its first rising clock edge. If a sample is waiting, the next frame starts with no idle cycle. The three serial outputs pass through one register stage, so they trail the internal state by one system clock.

Top module: `dac_serial_tx`

## Requirements
- R1: While reset is held, bclk_o, sdata_o and le_o are 0 and s_ready is 1.
- R2: A frame lasts 24 bit slots of DIV system clocks each. Within a slot, bclk_o is low for DIV - DIV/2 cycles and then high for DIV/2 cycles, so the duty cycle is 50% when DIV is even.
- R3: sdata_o changes only in the cycle where bclk_o goes low or where a frame starts. It holds steady for as long as bclk_o is high.
- R4: Slots 0 to 5 carry s_data[17]. Slots 6 to 23 carry s_data[17] down to s_data[0], in that order.
- R5: le_o is low during slot 0, high from slot 1 through slot 23, and falls in the same cycle as the bit clock's falling edge that ends slot 23.
- R6: s_ready is 1 whenever no frame is in progress, and during the final system cycle of slot 23. It is 0 at every other time.
- R7: A sample accepted in the final cycle of a frame starts the next frame in the very next cycle, with no idle bit period.
- R8: While no frame is in progress, bclk_o, sdata_o and le_o stay at 0. They remain there until the next sample is accepted.
- R9: s_data has no effect on the outputs unless s_valid and s_ready are both 1 at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | A sample is offered |
| s_data | input | 18 | Two's-complement sample |
| s_ready | output | 1 | The block takes the offered sample at this edge |
| bclk_o | output | 1 | Bit clock to the DAC |
| sdata_o | output | 1 | Serial data, valid at the rising bclk_o edge |
| le_o | output | 1 | Latch enable; its falling edge transfers the word |

## Verification
A wrong divider phase shows up at once as a bit-clock level that is off by one cycle. A slot counter that skips or repeats a slot moves the strobe's falling edge and the s_ready pulse, and that is visible within one bit period. A shift register that is loaded or shifted at the wrong time corrupts sdata_o in the next slot. A busy flag that fails to clear either leaves s_ready low with an idle input, or lets bit-clock pulses through while no sample is queued. Each of these errors is therefore seen at the ports within one frame.

// File: rtl/dac_tx_pkg.sv
package dac_tx_pkg;
  localparam int SAMPLE_W = 18;
  localparam int FRAME_W  = 24;
  localparam int PAD_W    = FRAME_W - SAMPLE_W;
  localparam int LE_SLOT  = 1;

  function automatic logic [FRAME_W-1:0] sign_extend(input logic [SAMPLE_W-1:0] s);
    return {{PAD_W{s[SAMPLE_W-1]}}, s};
  endfunction

  function automatic int low_cycles(input int div);
    return div - div / 2;
  endfunction
endpackage

// File: rtl/dac_bit_timer.sv
module dac_bit_timer #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic slot_end,
  output logic bclk_lvl
);
  import dac_tx_pkg::*;
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int LO = low_cycles(DIV);

  logic [PW-1:0] phase;

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= '0;
    else if (restart) phase <= '0;
    else if (run) phase <= (phase == PW'(DIV - 1)) ? '0 : phase + 1'b1;
  end

  assign slot_end = run && (phase == PW'(DIV - 1));
  assign bclk_lvl = run && (phase >= PW'(LO));

  // R2
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= PW'(DIV - 1));
  // R2
  slot_end_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |=> !bclk_lvl);
endmodule

// File: rtl/dac_frame_seq.sv
module dac_frame_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic slot_end,
  output logic busy,
  output logic frame_end,
  output logic le_lvl
);
  import dac_tx_pkg::*;
  localparam int SW = $clog2(FRAME_W);

  logic [SW-1:0] slot;
  logic          last_slot;

  assign last_slot = (slot == SW'(FRAME_W - 1));
  assign frame_end = slot_end && last_slot;
  assign le_lvl    = busy && (slot >= SW'(LE_SLOT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      slot <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      slot <= '0;
    end else if (slot_end) begin
      if (last_slot) begin
        busy <= 1'b0;
        slot <= '0;
      end else begin
        slot <= slot + 1'b1;
      end
    end
  end

  // R6
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot <= SW'(FRAME_W - 1));
  // R8
  idle_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> slot == '0);
endmodule

// File: rtl/dac_word_shifter.sv
module dac_word_shifter (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           load,
  input  logic [dac_tx_pkg::SAMPLE_W-1:0] sample,
  input  logic                           shift,
  output logic                           head_bit
);
  import dac_tx_pkg::*;

  logic [FRAME_W-1:0] word;

  always_ff @(posedge clk) begin
    if (!rst_n) word <= '0;
    else if (load) word <= sign_extend(sample);
    else if (shift) word <= {word[FRAME_W-2:0], 1'b0};
  end

  assign head_bit = word[FRAME_W-1];
endmodule

// File: rtl/dac_serial_tx.sv
module dac_serial_tx #(
  parameter int DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        s_valid,
  input  logic [17:0] s_data,
  output logic        s_ready,
  output logic        bclk_o,
  output logic        sdata_o,
  output logic        le_o
);
  import dac_tx_pkg::*;

  logic accept, busy, slot_end, frame_end;
  logic bclk_lvl, le_lvl, head_bit;

  assign s_ready = !busy || frame_end;
  assign accept  = s_valid && s_ready;

  dac_bit_timer #(.DIV(DIV)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(busy), .restart(accept),
    .slot_end(slot_end), .bclk_lvl(bclk_lvl)
  );

  dac_frame_seq u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept), .slot_end(slot_end),
    .busy(busy), .frame_end(frame_end), .le_lvl(le_lvl)
  );

  dac_word_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept), .sample(s_data),
    .shift(slot_end), .head_bit(head_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_o  <= 1'b0;
      sdata_o <= 1'b0;
      le_o    <= 1'b0;
    end else begin
      bclk_o  <= bclk_lvl;
      sdata_o <= busy && head_bit;
      le_o    <= le_lvl;
    end
  end

  // R3
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_o && $past(bclk_o) |-> $stable(sdata_o));
  // R5
  le_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(le_o) |-> $fell(bclk_o));
  // R5
  le_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(le_o) |-> $fell(bclk_o));
  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !accept |=> !bclk_o && !le_o && !sdata_o);
  // R7
  frame_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ##1 (!le_o && !bclk_o));
endmodule

// File: tb/test_dac_serial_tx.sv
module test_dac_serial_tx;
  localparam int DIV = 4;
  localparam int FR  = 24;
  localparam int FLEN = DIV * FR;
  localparam int LO  = DIV - DIV / 2;

  logic clk = 1'b0;
  logic rst_n, s_valid, s_ready, bclk_o, sdata_o, le_o;
  logic [17:0] s_data;

  always #4 clk = ~clk;

  dac_serial_tx #(.DIV(DIV)) i_dac_serial_tx (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data),
    .s_ready(s_ready), .bclk_o(bclk_o), .sdata_o(sdata_o), .le_o(le_o)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic frame_bit(input logic [17:0] s, input int slot);
    if (slot < FR - 18) return s[17];
    return s[17 - (slot - (FR - 18))];
  endfunction

  logic [17:0] samples[$];
  int gaps[$];

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit m_busy = 0;
    int t = 0;
    logic [17:0] m_samp = '0;
    logic d_bclk = 0, d_sdata = 0, d_le = 0;
    logic e_bclk, e_sdata, e_le, e_ready, acc, prev_bclk, prev_sdata;
    int wait_cnt = 0, idle_tail = 0;
    bit chained = 0;

    samples = '{18'h1FFFF, 18'h20000, 18'h00000, 18'h3FFFF, 18'h15555, 18'h2AAAA, 18'h00001};
    gaps    = '{0, 0, 40, 0, 3, 150, 0};
    rst_n = 0; s_valid = 0; s_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 bclk", bclk_o, 1'b0);
    chk("R1 sdata", sdata_o, 1'b0);
    chk("R1 le", le_o, 1'b0);
    chk("R1 ready", s_ready, 1'b1);
    rst_n = 1;
    prev_bclk = 0; prev_sdata = 0;

    for (int cyc = 0; cyc < 15000; cyc++) begin
      @(negedge clk);
      chk(!m_busy && !chained ? "R8 bclk idle" : "R2 bclk", bclk_o, d_bclk);
      chk(chained ? "R7 sdata" : "R4 sdata", sdata_o, d_sdata);
      chk("R5 le", le_o, d_le);
      if (prev_bclk && bclk_o) chk("R3 sdata stable", sdata_o, prev_sdata);
      prev_bclk = bclk_o; prev_sdata = sdata_o;
      e_ready = !m_busy || (t == FLEN - 1);
      chk("R6 ready", s_ready, e_ready);
      e_bclk  = m_busy && ((t % DIV) >= LO);
      e_sdata = m_busy && frame_bit(m_samp, t / DIV);
      e_le    = m_busy && (t / DIV >= 1);
      d_bclk = e_bclk; d_sdata = e_sdata; d_le = e_le;
      if (chained && t >= DIV) chained = 0;

      if (samples.size() == 0) begin
        s_valid = 0; s_data = 18'($urandom); // R9: junk with valid low
        if (!m_busy) idle_tail++;
        if (idle_tail > 10) break;
      end else if (wait_cnt > 0) begin
        s_valid = 0; s_data = 18'($urandom); // R9
        wait_cnt--;
      end else begin
        s_valid = 1; s_data = samples[0];
      end

      acc = s_valid && e_ready;
      if (acc) begin
        chained = m_busy;
        m_samp = s_data; m_busy = 1; t = 0;
        void'(samples.pop_front());
        wait_cnt = gaps.pop_front();
      end else if (m_busy) begin
        if (t == FLEN - 1) begin m_busy = 0; t = 0; end
        else t++;
      end
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule